// File: doc/BRIEF.md
# Two-Port Byte-Lane Word Store

This block is a clocked word store of 2048 entries of 16 bits. Two ports, called left and right, can reach it at the same time, and each can reach every entry. A port has its own address, select, output gate, a pair of byte write strobes and a write-blocking input. Every signal is active low except the address and the data. A port does not use bidirectional pins. It has separate 16-bit write and read buses and a valid flag for each 8-bit lane, and that flag takes the place of a driven/floating pin state.

In a given access each byte lane of a port acts on its own. A lane whose strobe is low writes. A lane whose strobe is high is read when the output gate is open. Otherwise the lane stays quiet. One access can therefore write one half of a word and return the other half. A deselected port reports that it is asleep. A port whose blocking input is low drops its writes and reports no valid read data.

Writes land on the rising clock edge. Read data and valid flags are registered, so they appear one cycle after the access is presented. A read returns the contents as they stood before any write made at the same edge.

Top module: `dpm_array_top`

## Requirements
- R1: Each port addresses all 2048 words with an 11-bit address. A word written through one port can be read back through the other port at every address, including 0 and 2047.
- R2: While a port's select (`*_cs_n`) is high, that port changes no memory content whatever its strobes are. One cycle later its `*_sleep` is 1 and both bits of its `*_dout_vld` are 0.
- R3: With select low and blocking input high, a low `*_wstb_n[0]` stores `*_din[7:0]` into bits 7:0 and a low `*_wstb_n[1]` stores `*_din[15:8]` into bits 15:8 of the addressed word. A lane whose strobe is high keeps its stored byte.
- R4: With select low, output gate (`*_oe_n`) low and blocking input high, every lane whose strobe is high has its `*_dout_vld` bit (bit 0 for bits 7:0, bit 1 for bits 15:8) at 1 one cycle later. Its `*_dout` lane then holds the stored byte as it stood before that clock edge.
- R5: In one access a port may write one lane and read the other lane of the same word. The written lane is stored, and the read lane returns valid data.
- R6: With select low and output gate high, no lane of that port reports valid one cycle later, whatever its strobes are.
- R7: While a port's blocking input (`*_inhibit_n`) is low, its writes are dropped and the memory is left unchanged.
- R8: While a port's blocking input is low, both of its `*_dout_vld` bits are 0 one cycle later.
- R9: A lane whose `*_dout_vld` bit is 0 drives 0 on its 8 bits of `*_dout`.
- R10: When both ports write the same lane of the same address at one edge, the right port's byte is stored. Writes to different lanes of one word from the two ports are both stored.
- R11: While `rst_n` is low, both ports show `*_sleep` = 1, `*_dout_vld` = 0 and `*_dout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| l_addr | input | 11 | Left word address |
| l_cs_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output gate, active low |
| l_wstb_n | input | 2 | Left byte write strobes, bit 0 lower lane, bit 1 upper lane, active low |
| l_inhibit_n | input | 1 | Left write block, active low |
| l_din | input | 16 | Left write data |
| l_dout | output | 16 | Left read data, zero on invalid lanes |
| l_dout_vld | output | 2 | Left per-lane read valid |
| l_sleep | output | 1 | Left port deselected indication |
| r_addr | input | 11 | Right word address |
| r_cs_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output gate, active low |
| r_wstb_n | input | 2 | Right byte write strobes, bit 0 lower lane, bit 1 upper lane, active low |
| r_inhibit_n | input | 1 | Right write block, active low |
| r_din | input | 16 | Right write data |
| r_dout | output | 16 | Right read data, zero on invalid lanes |
| r_dout_vld | output | 2 | Right per-lane read valid |
| r_sleep | output | 1 | Right port deselected indication |

## Verification
The bench writes a lower lane while reading the upper lane of the same word from the other port. A design that forwarded the new byte, or let one lane's strobe gate the other lane, would return the wrong half. It also writes a lane and reads the opposite lane through a single port, which exposes decoding that couples the two lanes. Blocked and deselected writes are followed by read-back at the same address, so a design that let the strobe through would show the corrupted word. Same-address collisions, both full-word and split-lane, check that the right port wins on a shared lane and that split lanes merge instead of one port overwriting the whole word.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int unsigned DPM_ADDR_W = 11;
  localparam int unsigned DPM_LANE_W = 8;
  localparam int unsigned DPM_LANES  = 2;
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode #(
  parameter int unsigned LANES = dpm_pkg::DPM_LANES
) (
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] wstb_n,
  input  logic             inhibit_n,
  output logic [LANES-1:0] we,
  output logic [LANES-1:0] re,
  output logic             sleep
);
  logic active;

  always_comb begin
    active = ~cs_n;
    sleep  = cs_n;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      we[g] = active & ~wstb_n[g] & inhibit_n;
      re[g] = active &  wstb_n[g] & ~oe_n & inhibit_n;
    end
  end
endmodule

// File: rtl/dpm_mem_core.sv
module dpm_mem_core #(
  parameter int unsigned ADDR_W = dpm_pkg::DPM_ADDR_W,
  parameter int unsigned LANE_W = dpm_pkg::DPM_LANE_W,
  parameter int unsigned LANES  = dpm_pkg::DPM_LANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        l_addr,
  input  logic [LANE_W*LANES-1:0]  l_din,
  input  logic [LANES-1:0]         l_we,
  input  logic [LANES-1:0]         l_re,
  output logic [LANE_W*LANES-1:0]  l_rdata,
  input  logic [ADDR_W-1:0]        r_addr,
  input  logic [LANE_W*LANES-1:0]  r_din,
  input  logic [LANES-1:0]         r_we,
  input  logic [LANES-1:0]         r_re,
  output logic [LANE_W*LANES-1:0]  r_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] l_rd_q, l_rd_d;
    logic [LANE_W-1:0] r_rd_q, r_rd_d;

    // Storage: left applied first so a same-lane same-address right write wins.
    always_ff @(posedge clk) begin
      if (l_we[g]) mem[l_addr] <= l_din[g*LANE_W +: LANE_W];
      if (r_we[g]) mem[r_addr] <= r_din[g*LANE_W +: LANE_W];
    end

    always_comb begin
      l_rd_d = l_re[g] ? mem[l_addr] : l_rd_q;
      r_rd_d = r_re[g] ? mem[r_addr] : r_rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_rd_q <= '0;
        r_rd_q <= '0;
      end else begin
        l_rd_q <= l_rd_d;
        r_rd_q <= r_rd_d;
      end
    end

    assign l_rdata[g*LANE_W +: LANE_W] = l_rd_q;
    assign r_rdata[g*LANE_W +: LANE_W] = r_rd_q;

    // R10: right byte survives a same-lane collision
    a_r10_right_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (l_we[g] && r_we[g] && (l_addr == r_addr))
      |=> (mem[$past(r_addr)] == $past(r_din[g*LANE_W +: LANE_W])));

    // R3: a lone left lane write lands in storage
    a_r3_left_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (l_we[g] && !(r_we[g] && (r_addr == l_addr)))
      |=> (mem[$past(l_addr)] == $past(l_din[g*LANE_W +: LANE_W])));
  end
endmodule

// File: rtl/dpm_port_out.sv
module dpm_port_out #(
  parameter int unsigned LANE_W = dpm_pkg::DPM_LANE_W,
  parameter int unsigned LANES  = dpm_pkg::DPM_LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        re,
  input  logic                    sleep_d,
  input  logic [LANE_W*LANES-1:0] rdata,
  output logic [LANE_W*LANES-1:0] dout,
  output logic [LANES-1:0]        dout_vld,
  output logic                    sleep
);
  logic [LANES-1:0] vld_q, vld_d;
  logic             sleep_q, sleep_d2;

  always_comb begin
    vld_d    = re;
    sleep_d2 = sleep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      sleep_q <= 1'b1;
    end else begin
      vld_q   <= vld_d;
      sleep_q <= sleep_d2;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*LANE_W +: LANE_W] = vld_q[g] ? rdata[g*LANE_W +: LANE_W] : '0;
  end

  assign dout_vld = vld_q;
  assign sleep    = sleep_q;
endmodule

// File: rtl/dpm_array_top.sv
module dpm_array_top #(
  parameter int unsigned ADDR_W = dpm_pkg::DPM_ADDR_W,
  parameter int unsigned LANE_W = dpm_pkg::DPM_LANE_W,
  parameter int unsigned LANES  = dpm_pkg::DPM_LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       l_addr,
  input  logic                    l_cs_n,
  input  logic                    l_oe_n,
  input  logic [LANES-1:0]        l_wstb_n,
  input  logic                    l_inhibit_n,
  input  logic [LANE_W*LANES-1:0] l_din,
  output logic [LANE_W*LANES-1:0] l_dout,
  output logic [LANES-1:0]        l_dout_vld,
  output logic                    l_sleep,
  input  logic [ADDR_W-1:0]       r_addr,
  input  logic                    r_cs_n,
  input  logic                    r_oe_n,
  input  logic [LANES-1:0]        r_wstb_n,
  input  logic                    r_inhibit_n,
  input  logic [LANE_W*LANES-1:0] r_din,
  output logic [LANE_W*LANES-1:0] r_dout,
  output logic [LANES-1:0]        r_dout_vld,
  output logic                    r_sleep
);
  localparam int unsigned DATA_W = LANE_W * LANES;

  logic [LANES-1:0]  l_we, l_re, r_we, r_re;
  logic              l_sleep_d, r_sleep_d;
  logic [DATA_W-1:0] l_rdata, r_rdata;

  dpm_port_decode #(.LANES(LANES)) u_l_dec (
    .cs_n(l_cs_n), .oe_n(l_oe_n), .wstb_n(l_wstb_n), .inhibit_n(l_inhibit_n),
    .we(l_we), .re(l_re), .sleep(l_sleep_d));

  dpm_port_decode #(.LANES(LANES)) u_r_dec (
    .cs_n(r_cs_n), .oe_n(r_oe_n), .wstb_n(r_wstb_n), .inhibit_n(r_inhibit_n),
    .we(r_we), .re(r_re), .sleep(r_sleep_d));

  dpm_mem_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_core (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_din(l_din), .l_we(l_we), .l_re(l_re), .l_rdata(l_rdata),
    .r_addr(r_addr), .r_din(r_din), .r_we(r_we), .r_re(r_re), .r_rdata(r_rdata));

  dpm_port_out #(.LANE_W(LANE_W), .LANES(LANES)) u_l_out (
    .clk(clk), .rst_n(rst_n), .re(l_re), .sleep_d(l_sleep_d), .rdata(l_rdata),
    .dout(l_dout), .dout_vld(l_dout_vld), .sleep(l_sleep));

  dpm_port_out #(.LANE_W(LANE_W), .LANES(LANES)) u_r_out (
    .clk(clk), .rst_n(rst_n), .re(r_re), .sleep_d(r_sleep_d), .rdata(r_rdata),
    .dout(r_dout), .dout_vld(r_dout_vld), .sleep(r_sleep));

  // R2: deselected port sleeps and shows nothing
  a_r2_left_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    l_cs_n |=> (l_sleep && (l_dout_vld == '0)));
  a_r2_right_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    r_cs_n |=> (r_sleep && (r_dout_vld == '0)));

  // R8: blocked port reports no valid lane
  a_r8_left_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !l_inhibit_n) |=> (l_dout_vld == '0));
  a_r8_right_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_cs_n && !r_inhibit_n) |=> (r_dout_vld == '0));

  // R6: closed output gate gives no valid lane
  a_r6_left_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && l_oe_n) |=> (l_dout_vld == '0));
  a_r6_right_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_cs_n && r_oe_n) |=> (r_dout_vld == '0));

  // R4: full read on an open, unblocked port returns both lanes
  a_r4_left_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !l_oe_n && l_inhibit_n && (l_wstb_n == '1)) |=> (l_dout_vld == '1));
  a_r4_right_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_cs_n && !r_oe_n && r_inhibit_n && (r_wstb_n == '1)) |=> (r_dout_vld == '1));
endmodule

// File: tb/dpm_array_top_bench.sv
module dpm_array_top_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [10:0] addr;
    logic        cs_n, oe_n, inh_n;
    logic [1:0]  wstb_n;
    logic [15:0] din;
  } pin_t;

  typedef struct {
    logic [15:0] l_dat, r_dat;
    logic [1:0]  l_vld, r_vld;
    logic        l_slp, r_slp;
    string       tag;
  } exp_t;

  logic clk, rst_n;
  logic [10:0] l_addr, r_addr;
  logic l_cs_n, l_oe_n, l_inhibit_n, r_cs_n, r_oe_n, r_inhibit_n;
  logic [1:0] l_wstb_n, r_wstb_n, l_dout_vld, r_dout_vld;
  logic [15:0] l_din, r_din, l_dout, r_dout;
  logic l_sleep, r_sleep;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  exp_t q[$];
  logic [15:0] shadow [2048];

  dpm_array_top u_dpm_array_top (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_wstb_n(l_wstb_n),
    .l_inhibit_n(l_inhibit_n), .l_din(l_din), .l_dout(l_dout),
    .l_dout_vld(l_dout_vld), .l_sleep(l_sleep),
    .r_addr(r_addr), .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_wstb_n(r_wstb_n),
    .r_inhibit_n(r_inhibit_n), .r_din(r_din), .r_dout(r_dout),
    .r_dout_vld(r_dout_vld), .r_sleep(r_sleep));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic pin_t idle();
    pin_t p;
    p.addr = '0; p.cs_n = 1; p.oe_n = 1; p.inh_n = 1; p.wstb_n = 2'b11; p.din = '0;
    return p;
  endfunction

  function automatic pin_t wr(logic [10:0] a, logic [1:0] stb, logic [15:0] d);
    pin_t p;
    p.addr = a; p.cs_n = 0; p.oe_n = 1; p.inh_n = 1; p.wstb_n = stb; p.din = d;
    return p;
  endfunction

  function automatic pin_t rd(logic [10:0] a);
    pin_t p;
    p.addr = a; p.cs_n = 0; p.oe_n = 0; p.inh_n = 1; p.wstb_n = 2'b11; p.din = '0;
    return p;
  endfunction

  function automatic logic [1:0] vld_of(pin_t p);
    logic [1:0] v;
    for (int i = 0; i < 2; i++) v[i] = !p.cs_n && p.wstb_n[i] && !p.oe_n && p.inh_n;
    return v;
  endfunction

  function automatic logic [15:0] dat_of(pin_t p, logic [1:0] v);
    logic [15:0] d;
    for (int i = 0; i < 2; i++) d[i*8 +: 8] = v[i] ? shadow[p.addr][i*8 +: 8] : 8'h00;
    return d;
  endfunction

  task automatic put_writes(pin_t p);
    for (int i = 0; i < 2; i++)
      if (!p.cs_n && !p.wstb_n[i] && p.inh_n) shadow[p.addr][i*8 +: 8] = p.din[i*8 +: 8];
  endtask

  // Driver: present one access on both ports, push the expected result.
  task automatic access(pin_t lp, pin_t rp, string tag);
    exp_t e;
    @(negedge clk);
    l_addr = lp.addr; l_cs_n = lp.cs_n; l_oe_n = lp.oe_n; l_inhibit_n = lp.inh_n;
    l_wstb_n = lp.wstb_n; l_din = lp.din;
    r_addr = rp.addr; r_cs_n = rp.cs_n; r_oe_n = rp.oe_n; r_inhibit_n = rp.inh_n;
    r_wstb_n = rp.wstb_n; r_din = rp.din;
    e.l_vld = vld_of(lp); e.r_vld = vld_of(rp);
    e.l_dat = dat_of(lp, e.l_vld); e.r_dat = dat_of(rp, e.r_vld);
    e.l_slp = lp.cs_n; e.r_slp = rp.cs_n;
    e.tag = tag;
    put_writes(lp);
    put_writes(rp); // right applied last: R10
    q.push_back(e);
  endtask

  // Monitor: after each edge, pop and compare.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({30'd0, l_dout_vld}, {30'd0, e.l_vld}, {e.tag, " left vld"});
        check({16'd0, l_dout}, {16'd0, e.l_dat}, {e.tag, " left data R9"});
        check({31'd0, l_sleep}, {31'd0, e.l_slp}, {e.tag, " left sleep"});
        check({30'd0, r_dout_vld}, {30'd0, e.r_vld}, {e.tag, " right vld"});
        check({16'd0, r_dout}, {16'd0, e.r_dat}, {e.tag, " right data R9"});
        check({31'd0, r_sleep}, {31'd0, e.r_slp}, {e.tag, " right sleep"});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pin_t p;
    rst_n = 0;
    l_addr = '0; l_cs_n = 1; l_oe_n = 1; l_inhibit_n = 1; l_wstb_n = 2'b11; l_din = '0;
    r_addr = '0; r_cs_n = 1; r_oe_n = 1; r_inhibit_n = 1; r_wstb_n = 2'b11; r_din = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({31'd0, l_sleep}, 32'd1, "R11 left sleep");
    check({30'd0, l_dout_vld}, 32'd0, "R11 left vld");
    check({16'd0, l_dout}, 32'd0, "R11 left data");
    check({31'd0, r_sleep}, 32'd1, "R11 right sleep");
    check({30'd0, r_dout_vld}, 32'd0, "R11 right vld");
    check({16'd0, r_dout}, 32'd0, "R11 right data");
    rst_n = 1;

    // R1 R3: full word writes at the edges of the range
    access(wr(11'd0, 2'b00, 16'hA1B2), idle(), "R1 R3 full write");
    access(wr(11'd2047, 2'b00, 16'h3C4D), wr(11'd1000, 2'b00, 16'h5566), "R1 both write");
    access(wr(11'd5, 2'b00, 16'h1234), rd(11'd0), "R1 R4 cross read 0");
    access(rd(11'd2047), rd(11'd1000), "R1 R4 reads");
    access(rd(11'd1000), rd(11'd2047), "R1 R4 cross read 2047");
    // R3 lower-only write; R4 same-edge read sees old word
    access(wr(11'd5, 2'b10, 16'hFFEF), rd(11'd5), "R3 R4 read-first");
    access(rd(11'd5), idle(), "R3 lower lane only");
    // R5 mixed lane on the right: upper write, lower read
    p = wr(11'd5, 2'b01, 16'h9A77); p.oe_n = 0;
    access(idle(), p, "R5 right mixed");
    access(rd(11'd5), rd(11'd5), "R5 read back");
    // R5 mixed on the left: lower write, upper read
    p = wr(11'd5, 2'b10, 16'h0042); p.oe_n = 0;
    access(p, idle(), "R5 left mixed");
    access(rd(11'd5), idle(), "R5 left read back");
    // R2 deselected port with strobes low
    p = wr(11'd5, 2'b00, 16'hFFFF); p.cs_n = 1; p.oe_n = 0;
    access(p, idle(), "R2 deselected");
    access(rd(11'd5), idle(), "R2 no change");
    // R6 closed gate, with and without a lane write
    p = rd(11'd0); p.oe_n = 1;
    access(p, idle(), "R6 gate closed");
    access(wr(11'd0, 2'b10, 16'h00C3), idle(), "R6 lane write gate closed");
    access(rd(11'd0), idle(), "R6 read back");
    // R7 R8 blocked ports
    p = wr(11'd0, 2'b00, 16'hFFFF); p.inh_n = 0;
    begin
      pin_t p2;
      p2 = rd(11'd0); p2.inh_n = 0;
      access(p, p2, "R7 R8 blocked");
      p2 = wr(11'd2047, 2'b00, 16'h0000); p2.inh_n = 0;
      access(rd(11'd0), p2, "R7 right blocked");
    end
    access(rd(11'd0), rd(11'd2047), "R7 no change");
    // R10 collisions
    access(wr(11'd100, 2'b00, 16'h1111), wr(11'd100, 2'b00, 16'h2222), "R10 full collision");
    access(rd(11'd100), idle(), "R10 right wins");
    access(wr(11'd200, 2'b10, 16'h00AA), wr(11'd200, 2'b01, 16'hBB00), "R10 split lanes");
    access(rd(11'd200), rd(11'd200), "R10 merged");
    access(wr(11'd300, 2'b10, 16'h0055), wr(11'd300, 2'b00, 16'h6677), "R10 partial collision");
    access(idle(), rd(11'd300), "R10 partial result");
    access(idle(), idle(), "R2 idle");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule